// File: doc/BRIEF.md
# Rising-Edge Phase-In Delay Unit

This block sits between the secondary-side timing inputs and the synchronous rectifier gate drivers. For each channel it copies the logic level of a timing input to a drive output. A falling input edge passes with one register of latency. A rising input edge is held back by an extra number of clock cycles. That number scales with a delay coefficient and inversely with a live digital reference code. While the soft-start reference ramps up from zero, the extra rising-edge delay shrinks. Each rectifier therefore starts out conducting only as a diode, takes on a growing share of every switching period, and ends fully synchronous once the reference reaches its nominal code.

The delay in cycles is `ceil(coef * REF_NOM / ref)`, capped at `DMAX`. At the nominal reference this is exactly `coef` cycles. The block never divides. Each channel adds the sampled reference into an accumulator once per cycle and rises when the accumulator reaches `coef * REF_NOM`, which needs only an adder and a comparator per channel. A bypass input removes the extra delay from every edge.

Top module: `rise_phase_delay`

## Requirements
- R1: In every state, a channel whose input is sampled low at a clock edge has its output low after that same edge, so a falling edge sees one cycle of latency and no extra delay.
- R2: When `bypass` is 1 or `coef` is 0, a channel whose input is first sampled high at edge k has its output high after edge k, with no extra delay.
- R3: Otherwise, the output goes high after edge k+n, where n = min(ceil(coef*REF_NOM/ref), DMAX), using the `ref_code` sampled at edge k.
- R4: With `ref_code` equal to REF_NOM (200 by default), the extra rising delay equals `coef` cycles.
- R5: Changing `ref_code` while a rising delay is pending has no effect on that delay.
- R6: If the input falls before its delay has elapsed, the output stays low for the whole pulse and after it, so the rectifier conducts only as a diode.
- R7: A `ref_code` of 0 gives the maximum delay of DMAX cycles (1000 by default). A ratio above DMAX is also capped at DMAX.
- R8: Raising `bypass` while a delay is pending (input still high) drives the output high after the next edge.
- R9: Each channel has its own delay counter. Activity on one channel does not move the other channel's output or its timing.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drive_in | input | NCH | Per-channel timing inputs |
| coef | input | COEF_W | Rising-delay coefficient, in cycles at the nominal reference |
| ref_code | input | REF_W | Live soft-start reference code |
| bypass | input | 1 | 1 removes the extra rising delay |
| drive_out | output | NCH | Per-channel delayed drive signals |

## Verification
The bench measures the rising delay at several reference codes that do not divide the target evenly, including a code above nominal. A design that truncates instead of rounding up would rise one cycle early. A design that tracks the live code instead of the code latched at the edge would shorten a pending delay when the reference jumps mid-delay.

The bench sends pulses shorter than the current delay. A design that fails to cancel the pending rise would emit a stray late pulse after the input has already fallen. A zero reference code and a very large ratio both test the cap. Without the cap, a zero code would hang high-pending forever, and a large ratio would wrap its counter and give a short delay.

Staggered edges on the two channels test that each channel keeps its own counter. A design that shares one counter would mistime the second channel.

// File: rtl/phasein_pkg.sv
package phasein_pkg;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_HIGH = 2'd2
  } ch_state_e;

endpackage

// File: rtl/phasein_ratio.sv
// Division by repeated addition: reach goes high on the cycle in which one
// more step brings acc to the target, or the step count to its cap.
module phasein_ratio #(
  parameter int REF_W = 8,
  parameter int TW    = 16,
  parameter int DMAX  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             adv,
  input  logic [REF_W-1:0] ref_in,
  input  logic [TW-1:0]    tgt_in,
  output logic             reach
);

  localparam int CW = $clog2(DMAX + 1);
  localparam int AW = TW + 1;

  logic [REF_W-1:0] ref_q, ref_d;
  logic [TW-1:0]    tgt_q, tgt_d;
  logic [AW-1:0]    acc_q, acc_d, acc_step;
  logic [CW-1:0]    cnt_q, cnt_d, cnt_step;

  always_comb begin
    acc_step = acc_q + AW'(ref_q);
    cnt_step = cnt_q + CW'(1);
    reach    = (acc_step >= AW'(tgt_q)) || (cnt_step >= CW'(DMAX));
  end

  always_comb begin
    ref_d = ref_q;
    tgt_d = tgt_q;
    acc_d = acc_q;
    cnt_d = cnt_q;
    if (load) begin
      ref_d = ref_in;
      tgt_d = tgt_in;
      acc_d = '0;
      cnt_d = '0;
    end else if (adv) begin
      acc_d = acc_step;
      cnt_d = cnt_step;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q <= '0;
      tgt_q <= '0;
      acc_q <= '0;
      cnt_q <= '0;
    end else if (load || adv) begin
      ref_q <= ref_d;
      tgt_q <= tgt_d;
      acc_q <= acc_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/phasein_chan.sv
module phasein_chan
  import phasein_pkg::*;
#(
  parameter int REF_W = 8,
  parameter int TW    = 16,
  parameter int DMAX  = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic             bypass,
  input  logic [REF_W-1:0] ref_in,
  input  logic [TW-1:0]    tgt_in,
  output logic             dout
);

  ch_state_e st_q, st_d;
  logic      load, adv, reach;

  phasein_ratio #(
    .REF_W (REF_W),
    .TW    (TW),
    .DMAX  (DMAX)
  ) u_ratio (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load),
    .adv    (adv),
    .ref_in (ref_in),
    .tgt_in (tgt_in),
    .reach  (reach)
  );

  always_comb begin
    st_d = st_q;
    load = 1'b0;
    adv  = 1'b0;
    unique case (st_q)
      CH_IDLE: begin
        if (din) begin
          if (bypass || (tgt_in == '0)) begin
            st_d = CH_HIGH;
          end else begin
            st_d = CH_WAIT;
            load = 1'b1;
          end
        end
      end
      CH_WAIT: begin
        if (!din) begin
          st_d = CH_IDLE;
        end else begin
          adv = 1'b1;
          if (bypass || reach) st_d = CH_HIGH;
        end
      end
      CH_HIGH: begin
        if (!din) st_d = CH_IDLE;
      end
      default: st_d = CH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CH_IDLE;
    else        st_q <= st_d;
  end

  assign dout = (st_q == CH_HIGH);

endmodule

// File: rtl/rise_phase_delay.sv
module rise_phase_delay #(
  parameter int NCH     = 2,
  parameter int COEF_W  = 8,
  parameter int REF_W   = 8,
  parameter int REF_NOM = 200,
  parameter int DMAX    = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    drive_in,
  input  logic [COEF_W-1:0] coef,
  input  logic [REF_W-1:0]  ref_code,
  input  logic              bypass,
  output logic [NCH-1:0]    drive_out
);

  localparam int TW = COEF_W + $clog2(REF_NOM + 1);

  logic [TW-1:0] target;

  always_comb target = TW'(coef) * TW'(REF_NOM);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    phasein_chan #(
      .REF_W (REF_W),
      .TW    (TW),
      .DMAX  (DMAX)
    ) u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .din    (drive_in[g]),
      .bypass (bypass),
      .ref_in (ref_code),
      .tgt_in (target),
      .dout   (drive_out[g])
    );
  end

endmodule

// File: rtl/rise_phase_delay_chk.sv
module rise_phase_delay_chk #(
  parameter int NCH    = 2,
  parameter int COEF_W = 8,
  parameter int REF_W  = 8,
  parameter int DMAX   = 1000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NCH-1:0]    drive_in,
  input logic [COEF_W-1:0] coef,
  input logic [REF_W-1:0]  ref_code,
  input logic              bypass,
  input logic [NCH-1:0]    drive_out
);

  localparam int WW = $clog2(DMAX + 3);

  always_comb begin
    if (!rst_n) a_r10_reset_low: assert (drive_out == '0);
  end

  for (genvar g = 0; g < NCH; g++) begin : g_chk
    logic [WW-1:0] wait_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             wait_q <= '0;
      else if (drive_in[g] && !drive_out[g]) begin
        if (wait_q != {WW{1'b1}})             wait_q <= wait_q + WW'(1);
      end else                                wait_q <= '0;
    end

    a_r1_fall_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !drive_in[g] |=> !drive_out[g]);

    a_r2_bypass_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_in[g] && bypass) |=> drive_out[g]);

    a_r2_zero_coef_rise: assert property (@(posedge clk) disable iff (!rst_n)
      (drive_in[g] && coef == '0) |=> drive_out[g]);

    a_r6_rise_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_out[g]) |-> $past(drive_in[g]));

    a_r7_wait_capped: assert property (@(posedge clk) disable iff (!rst_n)
      wait_q <= WW'(DMAX + 1));
  end

endmodule

bind rise_phase_delay rise_phase_delay_chk #(
  .NCH    (NCH),
  .COEF_W (COEF_W),
  .REF_W  (REF_W),
  .DMAX   (DMAX)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .drive_in  (drive_in),
  .coef      (coef),
  .ref_code  (ref_code),
  .bypass    (bypass),
  .drive_out (drive_out)
);

// File: tb/tb_rise_phase_delay.sv
module tb_rise_phase_delay;

  localparam int PERIOD  = 10;
  localparam int NCH     = 2;
  localparam int COEF_W  = 8;
  localparam int REF_W   = 8;
  localparam int REF_NOM = 200;
  localparam int DMAX    = 1000;

  logic              clk;
  logic              rst_n;
  logic [NCH-1:0]    drive_in;
  logic [COEF_W-1:0] coef;
  logic [REF_W-1:0]  ref_code;
  logic              bypass;
  logic [NCH-1:0]    drive_out;

  int n_chk;
  int n_fail;
  bit done;

  rise_phase_delay #(
    .NCH (NCH), .COEF_W (COEF_W), .REF_W (REF_W),
    .REF_NOM (REF_NOM), .DMAX (DMAX)
  ) dut (
    .clk (clk), .rst_n (rst_n), .drive_in (drive_in), .coef (coef),
    .ref_code (ref_code), .bypass (bypass), .drive_out (drive_out)
  );

  initial clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_delay(input int c, input int r, input bit byp);
    int n;
    if (byp || c == 0) return 0;
    if (r == 0) return DMAX;
    n = (c * REF_NOM + r - 1) / r;
    return (n > DMAX) ? DMAX : n;
  endfunction

  task automatic measure(input int ch, output int n);
    n = 0;
    drive_in[ch] = 1'b1;
    for (int i = 0; i < DMAX + 10; i++) begin
      @(posedge clk); @(negedge clk);
      if (drive_out[ch]) break;
      n++;
    end
  endtask

  task automatic drop(input int ch, input string req);
    drive_in[ch] = 1'b0;
    @(posedge clk); @(negedge clk);
    check(req, int'(drive_out[ch]), 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic t_rise(input string req, input int c, input int r, input bit byp);
    int n;
    coef = COEF_W'(c); ref_code = REF_W'(r); bypass = byp;
    measure(0, n);
    check(req, n, exp_delay(c, r, byp));
    drop(0, "R1");
    bypass = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; drive_in = '1; coef = 8'd5; ref_code = 8'd200; bypass = 1'b1;
    repeat (3) @(negedge clk);
    check("R10", int'(drive_out), 0);
    drive_in = '0; bypass = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10", int'(drive_out), 0);
  endtask

  task automatic t_ref_change();
    int n;
    coef = 8'd5; ref_code = 8'd50;
    drive_in[0] = 1'b1;
    @(posedge clk); @(negedge clk);
    ref_code = 8'd200;
    n = 0;
    for (int i = 0; i < 100; i++) begin
      if (drive_out[0]) break;
      n++;
      @(posedge clk); @(negedge clk);
    end
    check("R5", n, 20);
    drop(0, "R1");
  endtask

  task automatic t_short();
    int hi;
    hi = 0;
    coef = 8'd5; ref_code = 8'd50;
    drive_in[0] = 1'b1;
    repeat (10) begin
      @(posedge clk); @(negedge clk);
      hi += int'(drive_out[0]);
    end
    drive_in[0] = 1'b0;
    repeat (30) begin
      @(posedge clk); @(negedge clk);
      hi += int'(drive_out[0]);
    end
    check("R6", hi, 0);
  endtask

  task automatic t_bypass_mid();
    coef = 8'd5; ref_code = 8'd50;
    drive_in[0] = 1'b1;
    repeat (3) @(negedge clk);
    check("R8", int'(drive_out[0]), 0);
    bypass = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R8", int'(drive_out[0]), 1);
    bypass = 1'b0;
    drop(0, "R1");
  endtask

  task automatic t_indep();
    int f0, f1, pre1;
    f0 = -1; f1 = -1; pre1 = 0;
    coef = 8'd5; ref_code = 8'd200;
    drive_in[0] = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk); @(negedge clk);
      if (drive_out[0] && f0 < 0) f0 = i;
      if (drive_out[1] && f1 < 0) f1 = i;
      if (i <= 1) pre1 += int'(drive_out[1]);
      if (i == 1) drive_in[1] = 1'b1;
    end
    check("R9", pre1, 0);
    check("R9", f0, 5);
    check("R9", f1, 7);
    drive_in[1] = 1'b0;
    drop(0, "R1");
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    drive_in = '0;
    @(negedge clk);
    t_reset();
    t_rise("R4", 5, 200, 1'b0);
    t_rise("R4", 12, 200, 1'b0);
    t_rise("R3", 5, 50, 1'b0);
    t_rise("R3", 5, 77, 1'b0);
    t_rise("R3", 5, 255, 1'b0);
    t_rise("R2", 5, 50, 1'b1);
    t_rise("R2", 0, 50, 1'b0);
    t_ref_change();
    t_short();
    t_bypass_mid();
    t_indep();
    t_rise("R7", 1, 0, 1'b0);
    t_rise("R7", 255, 1, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule